// File: doc/BRIEF.md
# Three-Channel Center-Aligned Complementary PWM Generator

This block produces gate drive for a three-leg inverter. A single up/down carrier counter is shared by three compare channels. Each channel turns its comparison against the carrier into a complementary high-side/low-side pair. A programmable dead band keeps the two outputs of a pair from being active together. Every pair has its own polarity control and its own per-output force overrides. Because the carrier rises and then falls, each pulse is symmetric around the carrier valley.

Software programs the block through a simple write port. Period, compare and dead-band values go into shadow registers. These reach the active registers only at the carrier peak. At that moment the block raises a one-cycle period pulse, which tells software it can supply the next set of duty values. Polarity and force settings act at once.

Top module: `cpwm_tri`

## Requirements
- R1: While `rst_n` is low, all six gate outputs and `period_evt` are low.
- R2: The carrier starts at 1, counts up by one per clock to the active reload value R, then down to 1, and repeats. A full period is 2R-2 clocks. `period_evt` is high for exactly the one cycle in which the rising carrier equals R. Reload is written at address 0.
- R3: Channel c, with compare written at address 5+c, has an internal PWM level that is high in cycles where the carrier is at most the active compare value. The level is registered once. With zero dead band and polarity 0, the high-side output is active for 2·cmp-1 consecutive clocks per period, centred on the valley, and the low-side output covers the rest of the period.
- R4: A compare value of 0 keeps the high side inactive for the whole period. A compare value at or above R keeps it active for the whole period.
- R5: Writes to reload, compare and dead band change no output until the next clock edge on which `period_evt` is high. On that edge all shadow values are copied into the active set together.
- R6: A dead band of D clocks, written at address 1, delays each rising output edge by D clocks after the PWM level changes, while falling edges are immediate. Per period the high side is active 2·cmp-1-D clocks and the low side 2R-2-(2·cmp-1)-D clocks, and the two sides of a pair are never active together.
- R7: Bit c of address 2 inverts both outputs of pair c from the cycle after the write.
- R8: Address 3 holds force enables and address 4 holds force levels. Bit 2c is the high side of pair c and bit 2c+1 is its low side. A forced output drives the stored level, whatever the PWM state and polarity.
- R9: A reload value below 2 is treated as 2, which gives a two-clock period.
- R10: A write that lands on the same clock edge as the period peak goes into the shadow register only. The copy made on that edge uses the shadow content from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register address |
| wr_data | input | DW (8) | Register write data |
| gate_hi | output | NCH (3) | High-side gate output per pair |
| gate_lo | output | NCH (3) | Low-side gate output per pair |
| period_evt | output | 1 | One-cycle pulse at the carrier peak |

## Verification
The sensitive coincidence is a register write that arrives on the very edge where the carrier peak copies the shadow set into the active set. The bench provokes it by waiting for a sample in which `period_evt` is high and driving a compare write into that same cycle. It then counts high-side active clocks over the next full period. The count must match the old compare value, and the new value must appear only one period later. A cycle-accurate scoreboard model checks every output in every clock throughout, including the cycles around this collision.

// File: rtl/cpwm3_pkg.sv
package cpwm3_pkg;

   // register addresses; compare channel c sits at ADR_CMP0 + c
   localparam int ADR_RELOAD = 0;
   localparam int ADR_DEAD   = 1;
   localparam int ADR_POL    = 2;
   localparam int ADR_FEN    = 3;
   localparam int ADR_FVAL   = 4;
   localparam int ADR_CMP0   = 5;

   // smallest period value that still yields a rise and a fall
   localparam int RELOAD_MIN = 2;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } cdir_e;

endpackage

// File: rtl/cpwm3_regs.sv
module cpwm3_regs import cpwm3_pkg::*; #(
   parameter int CNT_W   = 8,
   parameter int DT_W    = 8,
   parameter int NCH     = 3,
   parameter int AW      = 3,
   parameter int DW      = 8,
   parameter int RLD_RST = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [AW-1:0]             wr_addr,
   input  logic [DW-1:0]             wr_data,
   input  logic                      load,
   output logic [CNT_W-1:0]          rld_act,
   output logic [DT_W-1:0]           dt_act,
   output logic [NCH-1:0][CNT_W-1:0] cmp_act,
   output logic [NCH-1:0]            pol,
   output logic [2*NCH-1:0]          fen,
   output logic [2*NCH-1:0]          fval
);

   localparam logic [CNT_W-1:0] RLD_FLOOR = CNT_W'(RELOAD_MIN);
   localparam logic [CNT_W-1:0] RLD_INIT  = CNT_W'(RLD_RST);

   logic [CNT_W-1:0]          rld_sh;
   logic [DT_W-1:0]           dt_sh;
   logic [NCH-1:0][CNT_W-1:0] cmp_sh;

   function automatic logic hit(input logic [AW-1:0] a, input int target);
      return wr_en && (a == AW'(target));
   endfunction

   // period and dead band: shadow plus active copy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rld_sh  <= RLD_INIT;
         rld_act <= RLD_INIT;
         dt_sh   <= '0;
         dt_act  <= '0;
      end else begin
         if (load) begin
            rld_act <= (rld_sh < RLD_FLOOR) ? RLD_FLOOR : rld_sh;
            dt_act  <= dt_sh;
         end
         if (hit(wr_addr, ADR_RELOAD)) rld_sh <= wr_data[CNT_W-1:0];
         if (hit(wr_addr, ADR_DEAD))   dt_sh  <= wr_data[DT_W-1:0];
      end
   end

   // compare bank: one shadow/active pair per channel
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_sh  <= '0;
         cmp_act <= '0;
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (load) cmp_act[c] <= cmp_sh[c];
            if (hit(wr_addr, ADR_CMP0 + c)) cmp_sh[c] <= wr_data[CNT_W-1:0];
         end
      end
   end

   // immediate controls: polarity and overrides
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol  <= '0;
         fen  <= '0;
         fval <= '0;
      end else begin
         if (hit(wr_addr, ADR_POL))  pol  <= wr_data[NCH-1:0];
         if (hit(wr_addr, ADR_FEN))  fen  <= wr_data[2*NCH-1:0];
         if (hit(wr_addr, ADR_FVAL)) fval <= wr_data[2*NCH-1:0];
      end
   end

endmodule

// File: rtl/cpwm3_carrier.sv
module cpwm3_carrier import cpwm3_pkg::*; #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rld,
   output logic [CNT_W-1:0] cnt,
   output logic             rising,
   output logic             peak
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   cdir_e dir;

   assign rising = (dir == DIR_UP);
   assign peak   = rising && (cnt == rld);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= ONE;
         dir <= DIR_UP;
      end else if (peak) begin
         cnt <= cnt - ONE;
         dir <= DIR_DOWN;
      end else if (!rising && cnt <= ONE) begin
         cnt <= TWO;
         dir <= DIR_UP;
      end else if (rising) begin
         cnt <= cnt + ONE;
      end else begin
         cnt <= cnt - ONE;
      end
   end

endmodule

// File: rtl/cpwm3_pair.sv
module cpwm3_pair #(
   parameter int CNT_W = 8,
   parameter int DT_W  = 8,
   parameter int DB_EN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   input  logic [DT_W-1:0]  dt,
   input  logic             pol,
   input  logic [1:0]       fen,
   input  logic [1:0]       fval,
   output logic             gate_hi,
   output logic             gate_lo
);

   logic level;   // unregistered PWM level from the comparison
   logic hi_on;
   logic lo_on;

   assign level = (cnt <= cmp);

   if (DB_EN != 0) begin : g_db
      logic            lvl_q;
      logic [DT_W-1:0] hold;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q <= 1'b0;
            hold  <= DT_W'(1);   // both sides idle until the first edge
         end else if (level != lvl_q) begin
            lvl_q <= level;
            hold  <= dt;
         end else if (hold != '0) begin
            hold  <= hold - DT_W'(1);
         end
      end

      assign hi_on = lvl_q  && (hold == '0);
      assign lo_on = !lvl_q && (hold == '0);
   end else begin : g_nodb
      logic lvl_q;
      logic alive;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q <= 1'b0;
            alive <= 1'b0;
         end else begin
            lvl_q <= level;
            alive <= 1'b1;
         end
      end

      assign hi_on = lvl_q  && alive;
      assign lo_on = !lvl_q && alive;
   end

   // override and polarity stage
   assign gate_hi = fen[0] ? fval[0] : (hi_on ^ pol);
   assign gate_lo = fen[1] ? fval[1] : (lo_on ^ pol);

endmodule

// File: rtl/cpwm_tri.sv
module cpwm_tri import cpwm3_pkg::*; #(
   parameter int CNT_W   = 8,
   parameter int DT_W    = 8,
   parameter int NCH     = 3,
   parameter int AW      = 3,
   parameter int DW      = 8,
   parameter int RLD_RST = 10,
   parameter int DB_EN   = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [DW-1:0]  wr_data,
   output logic [NCH-1:0] gate_hi,
   output logic [NCH-1:0] gate_lo,
   output logic           period_evt
);

   // elaboration-time parameter checks
   if (DW < CNT_W || DW < DT_W || DW < 2*NCH) begin : g_bad_dw
      $error("cpwm_tri: DW too narrow for the register fields");
   end
   if (ADR_CMP0 + NCH > (1 << AW)) begin : g_bad_aw
      $error("cpwm_tri: AW cannot address all compare channels");
   end
   if (RLD_RST < RELOAD_MIN || RLD_RST >= (1 << CNT_W)) begin : g_bad_rst
      $error("cpwm_tri: RLD_RST out of range");
   end

   logic [CNT_W-1:0]          cnt;
   logic                      rising;
   logic [CNT_W-1:0]          rld_act;
   logic [DT_W-1:0]           dt_act;
   logic [NCH-1:0][CNT_W-1:0] cmp_act;
   logic [NCH-1:0]            pol;
   logic [2*NCH-1:0]          fen;
   logic [2*NCH-1:0]          fval;

   cpwm3_regs #(
      .CNT_W(CNT_W), .DT_W(DT_W), .NCH(NCH), .AW(AW), .DW(DW), .RLD_RST(RLD_RST)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .load    (period_evt),
      .rld_act (rld_act),
      .dt_act  (dt_act),
      .cmp_act (cmp_act),
      .pol     (pol),
      .fen     (fen),
      .fval    (fval)
   );

   cpwm3_carrier #(.CNT_W(CNT_W)) u_carrier (
      .clk    (clk),
      .rst_n  (rst_n),
      .rld    (rld_act),
      .cnt    (cnt),
      .rising (rising),
      .peak   (period_evt)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_pair
      cpwm3_pair #(.CNT_W(CNT_W), .DT_W(DT_W), .DB_EN(DB_EN)) u_pair (
         .clk     (clk),
         .rst_n   (rst_n),
         .cnt     (cnt),
         .cmp     (cmp_act[c]),
         .dt      (dt_act),
         .pol     (pol[c]),
         .fen     (fen[2*c+1:2*c]),
         .fval    (fval[2*c+1:2*c]),
         .gate_hi (gate_hi[c]),
         .gate_lo (gate_lo[c])
      );
   end

endmodule

// File: rtl/cpwm3_chk.sv
module cpwm3_chk #(
   parameter int CNT_W = 8,
   parameter int DT_W  = 8,
   parameter int NCH   = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NCH-1:0]            gate_hi,
   input logic [NCH-1:0]            gate_lo,
   input logic                      period_evt,
   input logic [CNT_W-1:0]          cnt,
   input logic                      rising,
   input logic [CNT_W-1:0]          rld_act,
   input logic [DT_W-1:0]           dt_act,
   input logic [NCH-1:0][CNT_W-1:0] cmp_act,
   input logic [NCH-1:0]            pol,
   input logic [2*NCH-1:0]          fen
);

   // R2: carrier never reaches zero and never climbs past the active reload
   p_cnt_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt != '0);
   p_rise_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rising |-> (cnt <= rld_act));
   // R2: the period pulse lasts one cycle and turns the carrier downward
   p_evt_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      period_evt |=> (!period_evt && !rising));

   // R5: active settings move only on the edge that closes a period
   p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !period_evt |=> ($stable(rld_act) && $stable(dt_act) && $stable(cmp_act)));

   for (genvar c = 0; c < NCH; c++) begin : g_pair_chk
      // R6: unforced sides of a pair never active together
      p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (!fen[2*c] && !fen[2*c+1]) |->
            !((gate_hi[c] ^ pol[c]) && (gate_lo[c] ^ pol[c])));
      // R4: a compare of zero held for two cycles leaves the high side idle
      p_cmp_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (cmp_act[c] == '0 && $past(cmp_act[c]) == '0 && !fen[2*c]) |->
            (gate_hi[c] == pol[c]));
   end

endmodule

bind cpwm_tri cpwm3_chk #(.CNT_W(CNT_W), .DT_W(DT_W), .NCH(NCH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .gate_hi    (gate_hi),
   .gate_lo    (gate_lo),
   .period_evt (period_evt),
   .cnt        (cnt),
   .rising     (rising),
   .rld_act    (rld_act),
   .dt_act     (dt_act),
   .cmp_act    (cmp_act),
   .pol        (pol),
   .fen        (fen)
);

// File: tb/cpwm_tri_tb.sv
module cpwm_tri_tb;

   localparam int NCH   = 3;
   localparam int LIMIT = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [NCH-1:0] gate_hi;
   logic [NCH-1:0] gate_lo;
   logic           period_evt;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;   // 50 MHz

   cpwm_tri u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .gate_hi    (gate_hi),
      .gate_lo    (gate_lo),
      .period_evt (period_evt)
   );

   // ---------------- reference model (from the requirements) ----------------
   int   m_cnt, a_rld, s_rld, a_dt, s_dt;
   bit   m_up;
   int   a_cmp[NCH];
   int   s_cmp[NCH];
   bit   rq[NCH];
   int   dc[NCH];
   logic [NCH-1:0]   m_pol;
   logic [2*NCH-1:0] m_fen, m_fval;
   logic [6:0] exp_q[$];

   always @(posedge clk) begin : mdl
      bit pk;
      bit lv;
      logic [NCH-1:0] eh, el;
      if (!rst_n) begin
         m_cnt = 1; m_up = 1; a_rld = 10; s_rld = 10; a_dt = 0; s_dt = 0;
         for (int c = 0; c < NCH; c++) begin
            a_cmp[c] = 0; s_cmp[c] = 0; rq[c] = 0; dc[c] = 1;
         end
         m_pol = '0; m_fen = '0; m_fval = '0;
      end else begin
         pk = m_up && (m_cnt == a_rld);
         for (int c = 0; c < NCH; c++) begin
            lv = (m_cnt <= a_cmp[c]);
            if (lv != rq[c]) begin rq[c] = lv; dc[c] = a_dt; end
            else if (dc[c] != 0) dc[c] = dc[c] - 1;
         end
         if (pk) begin m_cnt = m_cnt - 1; m_up = 0; end
         else if (!m_up && m_cnt == 1) begin m_cnt = 2; m_up = 1; end
         else if (m_up) m_cnt = m_cnt + 1;
         else m_cnt = m_cnt - 1;
         if (pk) begin
            a_rld = (s_rld < 2) ? 2 : s_rld;
            a_dt  = s_dt;
            for (int c = 0; c < NCH; c++) a_cmp[c] = s_cmp[c];
         end
         if (wr_en) begin
            case (wr_addr)
               3'd0: s_rld = int'(wr_data);
               3'd1: s_dt  = int'(wr_data);
               3'd2: m_pol = wr_data[NCH-1:0];
               3'd3: m_fen = wr_data[2*NCH-1:0];
               3'd4: m_fval = wr_data[2*NCH-1:0];
               default: s_cmp[int'(wr_addr) - 5] = int'(wr_data);
            endcase
         end
         for (int c = 0; c < NCH; c++) begin
            eh[c] = m_fen[2*c]   ? m_fval[2*c]   : ((rq[c]  && dc[c] == 0) ^ m_pol[c]);
            el[c] = m_fen[2*c+1] ? m_fval[2*c+1] : ((!rq[c] && dc[c] == 0) ^ m_pol[c]);
         end
         exp_q.push_back({(m_up && m_cnt == a_rld), el, eh});
      end
   end

   // ---------------- monitor ----------------
   always @(negedge clk) begin : mon
      logic [6:0] e_v;
      logic [6:0] a_v;
      if (rst_n && exp_q.size() > 0) begin
         e_v = exp_q.pop_front();
         a_v = {period_evt, gate_lo, gate_hi};
         n_chk++;
         if (a_v !== e_v) begin
            n_fail++;
            $display("FAIL %s cycle model: actual %b expected %b", cur_req, a_v, e_v);
         end
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > LIMIT) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, LIMIT);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- driver helpers ----------------
   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);   // called at a negedge
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_peaks(input int n);
      repeat (n) begin
         do @(negedge clk); while (!period_evt);
      end
   endtask

   int m_len;
   int m_hc[NCH];
   int m_lc[NCH];
   int m_both;

   task automatic measure();
      wait_peaks(1);
      m_len = 0; m_both = 0;
      for (int c = 0; c < NCH; c++) begin m_hc[c] = 0; m_lc[c] = 0; end
      do begin
         @(negedge clk);
         m_len++;
         for (int c = 0; c < NCH; c++) begin
            m_hc[c] += int'(gate_hi[c]);
            m_lc[c] += int'(gate_lo[c]);
            if (gate_hi[c] && gate_lo[c]) m_both++;
         end
      end while (!period_evt);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int hsum;
      repeat (3) @(negedge clk);
      chk("R1 gate_hi in reset", int'(gate_hi), 0);
      chk("R1 gate_lo in reset", int'(gate_lo), 0);
      chk("R1 period_evt in reset", int'(period_evt), 0);
      rst_n = 1'b1;

      cur_req = "R2 R3 R4";
      wr(5, 4); wr(6, 0); wr(7, 12); wr(0, 10);
      wait_peaks(2);
      measure();
      chk("R2 period length R=10", m_len, 18);
      chk("R3 high side cmp=4", m_hc[0], 7);
      chk("R3 low side cmp=4", m_lc[0], 11);
      chk("R4 high side cmp=0", m_hc[1], 0);
      chk("R4 low side cmp=0", m_lc[1], 18);
      chk("R4 high side cmp>=R", m_hc[2], 18);
      chk("R4 low side cmp>=R", m_lc[2], 0);

      cur_req = "R6";
      wr(1, 3);
      wait_peaks(2);
      measure();
      chk("R6 high side D=3", m_hc[0], 4);
      chk("R6 low side D=3", m_lc[0], 8);
      chk("R6 no overlap", m_both, 0);

      cur_req = "R5";
      wait_peaks(1);
      repeat (4) @(negedge clk);
      wr(5, 6);
      wait_peaks(2);
      measure();
      chk("R5 new compare after peak", m_hc[0], 8);
      chk("R5 low side after peak", m_lc[0], 4);

      cur_req = "R7";
      wr(2, 1);
      wait_peaks(1);
      measure();
      chk("R7 inverted high pin", m_hc[0], 10);
      chk("R7 inverted low pin", m_lc[0], 14);
      chk("R7 other pair untouched", m_hc[1], 0);
      wr(2, 0);

      cur_req = "R8";
      wr(3, 8'h03); wr(4, 8'h01);
      measure();
      chk("R8 forced high side", m_hc[0], 18);
      chk("R8 forced low side", m_lc[0], 0);
      wr(3, 0); wr(4, 0);
      wait_peaks(2);

      cur_req = "R10";
      do @(negedge clk); while (!period_evt);
      wr(5, 2);   // lands on the peak edge
      hsum = int'(gate_hi[0]);
      repeat (17) begin
         @(negedge clk);
         hsum += int'(gate_hi[0]);
      end
      chk("R10 period after collision uses old compare", hsum, 8);
      wait_peaks(2);
      measure();
      chk("R10 new compare one period later (R6 pulse within dead band)", m_hc[0], 0);
      chk("R6 low side with cmp=2 D=3", m_lc[0], 12);

      cur_req = "R9";
      wr(0, 0);
      wait_peaks(3);
      measure();
      chk("R9 reload 0 clamps to 2", m_len, 2);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule